// File: doc/BRIEF.md
# Programmable Binary Timer

This block is a timer built around a 16-stage binary counter. The counter advances on rising clock edges, but only in cycles where the `tick` enable is high. That enable takes the place of a free-running oscillator. A two-bit time-select input taps one counter stage as the timer output. The mapping from select code to stage is deliberately not monotonic, so it is not ordered by period length.

Two run modes are available:
- **Recycle mode**: the tapped stage drives the output continuously, as a square-wave divider.
- **Single-cycle mode**: an internal latch flips the output once, after half of the selected period, and then holds it. The latch re-arms only after a master reset or a change of the mode input.

The reset-time output level is set by a polarity input. Internally, all reset causes merge into one synchronous clear:
- the master reset;
- a power-up request, taken from the rising edge of `por_n` and gated by `auto_dis`;
- a change of the mode level.

Top module: `prog_timer`

## Requirements
- R1: The select code `tsel` = {a,b} taps a counter stage as follows. Stage n has period 2^n ticks and first goes high after 2^(n-1) ticks from clear.

  | `tsel` | Stage | Period (ticks) |
  |---|---|---|
  | 00 | 13 | 8192 |
  | 01 | 10 | 1024 |
  | 10 | 8 | 256 |
  | 11 | 16 | 65536 |

- R2: The counter advances by one at each rising clock edge where `tick` is 1 and no clear is pending. It holds when `tick` is 0. It wraps modulo 2^16.
- R3: While `mrst` is 1, the counter is cleared at every edge, whatever its count, and stays at zero. Counting stops.
- R4: With `auto_dis` = 0, a 0-to-1 transition of `por_n` clears the counter and the single-cycle latch at the next edge. With `auto_dis` = 1, the same transition has no effect.
- R5: While a clear is in effect (`mrst` high, or a power-up or mode-change request pending), `tout` equals `pol`. This holds even if `pol` changes during the reset.
- R6: With `mode` = 1 (recycle), `tout` = `pol` XOR (the level of the tapped stage).
- R7: With `mode` = 0 (single-cycle), `tout` = `pol` until the count reaches 2^(n-1) after a clear. From then on, `tout` = NOT `pol` and it stays there through further counts and counter wrap.
- R8: Any change of the `mode` level clears the counter and the single-cycle latch at the next edge. This re-arms single-cycle operation.
- R9: `busy` is 1 exactly when the block is in single-cycle mode, not in a clear, and its latch has not yet fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps on the rising edge |
| tick | input | 1 | Count enable; the oscillator stand-in |
| mrst | input | 1 | Master reset, active high |
| auto_dis | input | 1 | 0 enables the power-up reset request, 1 disables it |
| por_n | input | 1 | Power-good level; a rising edge is a power-up event |
| tsel | input | 2 | Time select {a,b} |
| pol | input | 1 | Output level during reset |
| mode | input | 1 | 1 selects recycle, 0 selects single-cycle |
| tout | output | 1 | Timer output |
| busy | output | 1 | Single-cycle timer armed and still running |

## Verification
The bench targets these corner cases:
- **Select mapping.** A design with the select mapping put in numeric order, or off by one stage, toggles at the wrong tick count under at least one select code.
- **Latch rule.** A single-cycle latch that follows the stage instead of holding would drop back after a full period or after counter wrap. Runs longer than a full 256-tick period and a 32768-tick half period expose this.
- **Re-arming.** Mode flips, power-up edges with the auto-reset enabled and disabled, and polarity changes during a held master reset all exercise the clear logic. A design that ignores `auto_dis`, misses the mode edge, or keeps counting during reset then shows a wrong output level.
- **Random stimulus.** Randomized stimulus mixes gappy ticks with all of the above.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

  typedef enum logic {
    RUN_ONESHOT = 1'b0,
    RUN_RECYCLE = 1'b1
  } run_mode_e;

  // A stage goes from 0 to 1 between the present and the next count.
  function automatic logic stage_rises(input logic now_lvl, input logic nxt_lvl);
    return (!now_lvl) && nxt_lvl;
  endfunction

  // Output level: polarity applied over the raw timer state.
  function automatic logic apply_pol(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

endpackage

// File: rtl/ptm_clear_ctl.sv
module ptm_clear_ctl (
  input  logic clk,
  input  logic mrst,
  input  logic auto_dis,
  input  logic por_n,
  input  logic mode,
  output logic clear,
  output logic por_evt,
  output logic mode_evt
);

  logic por_q;
  logic mode_q;

  // Samples without reset: these registers are the edge detectors themselves.
  always_ff @(posedge clk) begin
    por_q  <= por_n;
    mode_q <= mode;
  end

  assign por_evt  = por_n & ~por_q & ~auto_dis;
  assign mode_evt = mode ^ mode_q;
  assign clear    = mrst | por_evt | mode_evt;

endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step
);

  assign step    = tick & ~clear;
  assign cnt_nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (clear)     cnt <= '0;
    else if (step) cnt <= cnt_nxt;
  end

endmodule

// File: rtl/ptm_out_ctl.sv
module ptm_out_ctl
  import prog_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STG_00   = 13,
  parameter int STG_01   = 10,
  parameter int STG_10   = 8,
  parameter int STG_11   = 16,
  parameter bit HAS_BUSY = 1'b1
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [1:0]       tsel,
  input  logic             pol,
  input  logic             mode,
  output logic             tap_lvl,
  output logic             half_hit,
  output logic             latch,
  output logic             tout,
  output logic             busy
);

  localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

  // Select code to bit index: stage n is counter bit n-1.
  function automatic logic [IDX_W-1:0] tap_of(input logic [1:0] s);
    case (s)
      2'b00:   return IDX_W'(STG_00 - 1);
      2'b01:   return IDX_W'(STG_01 - 1);
      2'b10:   return IDX_W'(STG_10 - 1);
      default: return IDX_W'(STG_11 - 1);
    endcase
  endfunction

  logic [IDX_W-1:0] tap_idx;
  logic             raw;
  run_mode_e        run;

  assign run      = run_mode_e'(mode);
  assign tap_idx  = tap_of(tsel);
  assign tap_lvl  = cnt[tap_idx];
  assign half_hit = step & stage_rises(cnt[tap_idx], cnt_nxt[tap_idx]);

  always_ff @(posedge clk) begin
    if (clear)                                latch <= 1'b0;
    else if (half_hit && run == RUN_ONESHOT)  latch <= 1'b1;
  end

  always_comb begin
    if (clear)                    raw = 1'b0;
    else if (run == RUN_RECYCLE)  raw = tap_lvl;
    else                          raw = latch;
  end

  assign tout = apply_pol(raw, pol);

  generate
    if (HAS_BUSY) begin : g_busy
      assign busy = ~clear & (run == RUN_ONESHOT) & ~latch;
    end else begin : g_nobusy
      assign busy = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CNT_W    = 16,
  parameter int STG_00   = 13,
  parameter int STG_01   = 10,
  parameter int STG_10   = 8,
  parameter int STG_11   = 16,
  parameter bit HAS_BUSY = 1'b1
) (
  input  logic       clk,
  input  logic       tick,
  input  logic       mrst,
  input  logic       auto_dis,
  input  logic       por_n,
  input  logic [1:0] tsel,
  input  logic       pol,
  input  logic       mode,
  output logic       tout,
  output logic       busy
);

  logic             clear_w;
  logic             por_evt_w;
  logic             mode_evt_w;
  logic             step_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_nxt_w;
  logic             tap_lvl_w;
  logic             half_hit_w;
  logic             latch_w;

  ptm_clear_ctl u_clr (
    .clk      (clk),
    .mrst     (mrst),
    .auto_dis (auto_dis),
    .por_n    (por_n),
    .mode     (mode),
    .clear    (clear_w),
    .por_evt  (por_evt_w),
    .mode_evt (mode_evt_w)
  );

  ptm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .clear   (clear_w),
    .tick    (tick),
    .cnt     (cnt_w),
    .cnt_nxt (cnt_nxt_w),
    .step    (step_w)
  );

  ptm_out_ctl #(
    .CNT_W    (CNT_W),
    .STG_00   (STG_00),
    .STG_01   (STG_01),
    .STG_10   (STG_10),
    .STG_11   (STG_11),
    .HAS_BUSY (HAS_BUSY)
  ) u_out (
    .clk      (clk),
    .clear    (clear_w),
    .step     (step_w),
    .cnt      (cnt_w),
    .cnt_nxt  (cnt_nxt_w),
    .tsel     (tsel),
    .pol      (pol),
    .mode     (mode),
    .tap_lvl  (tap_lvl_w),
    .half_hit (half_hit_w),
    .latch    (latch_w),
    .tout     (tout),
    .busy     (busy)
  );

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             mrst,
  input logic             tick,
  input logic             mode,
  input logic             pol,
  input logic [1:0]       tsel,
  input logic             tout,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic             latch,
  input logic             clear,
  input logic             mode_evt
);

  // R3 / R5: master reset forces the output to the polarity level
  assert_reset_level_R5: assert property (@(posedge clk) mrst |-> (tout == pol && !busy));

  // R3: counter is zero one edge after master reset is seen
  assert_reset_clears_R3: assert property (@(posedge clk) mrst |=> (cnt == '0));

  // R2: no tick, no clear -> count holds
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (mrst)
    (!tick && !clear) |=> $stable(cnt));

  // R2: tick without clear -> count steps by one
  assert_step_R2: assert property (@(posedge clk) disable iff (mrst)
    (tick && !clear) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R7: a fired latch holds until a clear
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (mrst)
    (latch && !clear) |=> latch);

  // R8: a mode edge re-arms the timer
  assert_rearm_R8: assert property (@(posedge clk) disable iff (mrst)
    mode_evt |=> (cnt == '0 && !latch));

  // R9: busy only in single-cycle mode
  assert_busy_mode_R9: assert property (@(posedge clk) disable iff (mrst)
    busy |-> (!mode && !clear));

  // R6: without a tick or an input change, the output does not move
  assert_out_quiet_R6: assert property (@(posedge clk) disable iff (mrst)
    (!tick && !clear) |=> ($stable(tout) || !$stable(pol) || !$stable(tsel) ||
                           !$stable(mode) || clear));

endmodule

bind prog_timer prog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .mrst     (mrst),
  .tick     (tick),
  .mode     (mode),
  .pol      (pol),
  .tsel     (tsel),
  .tout     (tout),
  .busy     (busy),
  .cnt      (cnt_w),
  .latch    (latch_w),
  .clear    (clear_w),
  .mode_evt (mode_evt_w)
);

// File: tb/prog_timer_bench.sv
module prog_timer_bench;

  logic       clk = 1'b0;
  logic       tick, mrst, auto_dis, por_n, pol, mode;
  logic [1:0] tsel;
  logic       tout, busy;

  always #5 clk = ~clk;

  prog_timer u_prog_timer (
    .clk(clk), .tick(tick), .mrst(mrst), .auto_dis(auto_dis), .por_n(por_n),
    .tsel(tsel), .pol(pol), .mode(mode), .tout(tout), .busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state, kept from the requirements
  int m_cnt   = 0;
  bit m_latch = 1'b0;
  bit m_por_q = 1'b0;
  bit m_mode_q = 1'b0;

  function automatic int stage_n(logic [1:0] s);
    int tbl[4] = '{13, 10, 8, 16};   // R1 code order 00,01,10,11
    return tbl[s];
  endfunction

  function automatic bit stage_lvl(int c, logic [1:0] s);
    return ((c % (1 << stage_n(s))) >= (1 << (stage_n(s) - 1)));
  endfunction

  function automatic bit clr_now();
    return mrst || (por_n && !m_por_q && !auto_dis) || (mode != m_mode_q);
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    bit cl;
    bit e_out;
    bit e_busy;
    #2;
    cl     = clr_now();
    e_out  = cl ? pol : (mode ? (pol ^ stage_lvl(m_cnt, tsel)) : (pol ^ m_latch));
    e_busy = !cl && !mode && !m_latch;
    check(cl ? (mrst ? "R5" : tag) : tag, "tout", tout, e_out);
    check("R9", "busy", busy, e_busy);
    @(posedge clk);
    if (cl) begin
      m_cnt = 0;
      m_latch = 1'b0;
    end else if (tick) begin
      m_cnt = (m_cnt + 1) % 65536;
      if (!mode && (m_cnt % (1 << stage_n(tsel))) == (1 << (stage_n(tsel) - 1)))
        m_latch = 1'b1;
    end
    m_por_q  = por_n;
    m_mode_q = mode;
    #1;
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pulse_reset();
    mrst = 1'b1;
    cyc("R3");
    mrst = 1'b0;
  endtask

  initial begin
    #(2_000_000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all-requirements watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4541));
    mrst = 1'b1; por_n = 1'b0; auto_dis = 1'b1; tick = 1'b0;
    mode = 1'b1; pol = 1'b0; tsel = 2'b10;
    run("R3", 3);

    // R1 / R6: recycle divider on each select code
    mrst = 1'b0; tick = 1'b1;
    run("R1", 600);                        // stage 8
    tsel = 2'b01; pulse_reset(); run("R1", 2100);   // stage 10
    tsel = 2'b00; pol = 1'b1; pulse_reset(); run("R6", 8300); // stage 13, inverted

    // R2: gappy ticks
    tsel = 2'b10; pol = 1'b0; pulse_reset();
    for (int i = 0; i < 2000; i++) begin
      tick = $urandom_range(0, 1);
      cyc("R2");
    end
    tick = 1'b1;

    // R3 / R5: hold reset with ticks, flip polarity during reset
    run("R6", 150);
    mrst = 1'b1; run("R3", 4); pol = 1'b1; run("R5", 4); mrst = 1'b0;
    run("R3", 130);

    // R7: single-cycle on stage 8 through several full periods
    pol = 1'b0; mode = 1'b0; run("R7", 700);
    // R7 on stage 16: fire at 32768, hold afterwards
    tsel = 2'b11; pulse_reset(); run("R1", 33000);

    // R8: re-arm through a mode flip
    tsel = 2'b10; mode = 1'b1; cyc("R8"); mode = 1'b0; run("R8", 140);

    // R4: power-up edge, enabled then disabled
    mode = 1'b1; run("R4", 200);
    auto_dis = 1'b0; por_n = 1'b0; run("R4", 2); por_n = 1'b1; run("R4", 60);
    run("R4", 150);
    auto_dis = 1'b1; por_n = 1'b0; run("R4", 2); por_n = 1'b1; run("R4", 60);

    // Random mix
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 499) == 0) mrst = 1'b1; else mrst = 1'b0;
      if ($urandom_range(0, 399) == 0) mode = ~mode;
      if ($urandom_range(0, 299) == 0) pol = ~pol;
      if ($urandom_range(0, 599) == 0) tsel = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 199) == 0) por_n = ~por_n;
      if ($urandom_range(0, 299) == 0) auto_dis = ~auto_dis;
      cyc(mode ? "R6" : "R7");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule